// File: doc/BRIEF.md
# Prescaled Up-Counter with Compare Flag

This block is an 8-bit up-counter that advances on a tick chosen from a free-running divider chain. The chain runs on a fast peripheral clock, sixteen times the CPU clock. A 4-bit select input picks one of sixteen rates. The slowest rate is the CPU clock divided by 1024, and the fastest is the fast clock itself. One select value stops the counter. The divide-by-16 tap of the same chain is the CPU-clock enable. This enable paces every CPU-side action: register writes, flag clears and flag updates.

The CPU can write the counter and the compare value and read both back. A counter write is held for one CPU cycle before it lands. The block compares the counter with the compare value at all times, but only an increment that carries the counter into the compare value counts as a match. Such a match sets a sticky flag one CPU cycle later. The flag stays set until the CPU clears it.

Top module: `ptmr_top`

## Requirements
- R1: After reset the counter reads 0, the compare value reads 0 and the flag is 0.
- R2: With `clk_sel` = 0 the counter holds its value for as long as the select stays 0.
- R3: With `clk_sel` = 1, 2, 3 or 4 the counter advances by one every 1, 2, 4 or 8 fast-clock cycles.
- R4: `cpu_tick` is high for one fast cycle in every 16. With `clk_sel` = 5 the counter advances by one every 16 fast cycles, which is once per CPU cycle.
- R5: With `clk_sel` = s, for s from 6 to 15, the counter advances once every 16·2^(s−5) fast cycles, which is the CPU clock divided by 2 up to 1024.
- R6: A counter write is sampled on a fast edge where `cpu_tick` is high (a CPU edge). The counter still shows its old value after that edge and shows the written value after the next CPU edge. At that next edge the write overrides any increment.
- R7: A compare write is sampled on a CPU edge. The new value reads back on `cmp_value` right after that edge.
- R8: A match is raised only when an increment makes the counter equal to the compare value. Writing either register so that the two become equal never sets the flag.
- R9: After a match, the flag is still 0 right after the edge on which the counter takes the compare value. The flag becomes 1 at the next CPU edge.
- R10: The flag stays 1 until `flag_clr` is sampled high on a CPU edge. A clear pulse that falls only between CPU edges has no effect.
- R11: If a clear and a pending set reach the same CPU edge, the flag is 1 after that edge.
- R12: The counter wraps from 255 to 0 on the next tick with no extra delay. A compare value of 0 matches on that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast peripheral clock (16× CPU clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 4 | Tick rate select, 0 = stopped |
| cnt_wr_en | input | 1 | Counter write strobe, sampled on CPU edges |
| cnt_wr_data | input | 8 | Counter write value |
| cmp_wr_en | input | 1 | Compare write strobe, sampled on CPU edges |
| cmp_wr_data | input | 8 | Compare write value |
| flag_clr | input | 1 | Flag clear, sampled on CPU edges |
| cnt_value | output | 8 | Counter read-back |
| cmp_value | output | 8 | Compare read-back |
| cmp_flag | output | 1 | Sticky compare-match flag |
| cpu_tick | output | 1 | CPU-clock enable (divide-by-16 tap) |

## Verification
Two pairs of events can fall on one edge. The first pair is a flag clear and a pending flag set. The bench provokes it by letting the counter reach the compare value while the flag is already 1, then clearing on the very next CPU edge. It judges the result by requiring the flag to stay 1 and then fall on a later clear. The second pair is a delayed counter load and a prescaler increment. The bench provokes it by loading at the full fast rate and judges it by requiring the exact written value right after the load edge, followed by value+1 one fast cycle later.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int CNT_W     = 8;
    localparam int SEL_W     = 4;
    localparam int NSEL      = 2 ** SEL_W;
    localparam int DIV_W     = NSEL - 2;
    localparam int CPU_LOG2  = 4;
    localparam int CPU_SEL   = CPU_LOG2 + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } presc_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             ld_pend;
        logic [CNT_W-1:0] ld_data;
    } core_st_t;

    typedef struct packed {
        logic flag;
        logic pend;
    } flag_st_t;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             cnt_tick_o,
    output logic             cpu_tick_o
);
    presc_st_t st_d, st_q;
    logic [NSEL-1:0] taps;

    always_comb begin
        st_d     = st_q;
        st_d.div = st_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // tap s fires once every 2**(s-1) fast cycles; tap 0 never fires
    assign taps[0] = 1'b0;
    assign taps[1] = 1'b1;
    for (genvar s = 2; s < NSEL; s++) begin : g_tap
        assign taps[s] = &st_q.div[s-2:0];
    end

    assign cnt_tick_o = taps[sel_i];
    assign cpu_tick_o = taps[CPU_SEL];

    a_r4_cpu_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tick_o |=> !cpu_tick_o);
endmodule

// File: rtl/ptmr_count_core.sv
module ptmr_count_core
    import ptmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_tick_i,
    input  logic             cnt_tick_i,
    input  logic             stopped_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wd_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_wd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             match_o
);
    core_st_t st_d, st_q;
    logic     load;
    logic     step;

    always_comb begin
        st_d  = st_q;
        load  = cpu_tick_i && st_q.ld_pend;
        step  = cnt_tick_i && !load;
        if (load)
            st_d.cnt = st_q.ld_data;
        else if (step)
            st_d.cnt = st_q.cnt + 1'b1;
        if (cpu_tick_i) begin
            st_d.ld_pend = cnt_we_i;
            if (cnt_we_i) st_d.ld_data = cnt_wd_i;
            if (cmp_we_i) st_d.cmp     = cmp_wd_i;
        end
        match_o = step && ((st_q.cnt + 1'b1) == st_q.cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign cmp_o = st_q.cmp;

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_i && !(cpu_tick_i && st_q.ld_pend)) |=> $stable(st_q.cnt));
    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick_i && st_q.ld_pend) |=> (st_q.cnt == $past(st_q.ld_data)));
    a_r12_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick_i && !(cpu_tick_i && st_q.ld_pend) && st_q.cnt == '1) |=> (st_q.cnt == '0));
    a_r8_no_match_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick_i && st_q.ld_pend) |-> !match_o);
endmodule

// File: rtl/ptmr_flag.sv
module ptmr_flag
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_tick_i,
    input  logic match_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_tick_i) begin
            st_d.flag = (st_q.flag && !clr_i) || st_q.pend;
            st_d.pend = match_i;
        end else begin
            st_d.pend = st_q.pend || match_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    a_r9_rise_on_cpu_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(cpu_tick_i));
    a_r10_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_tick_i |=> $stable(st_q.flag));
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick_i && st_q.pend) |=> st_q.flag);
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       clk_sel,
    input  logic             cnt_wr_en,
    input  logic [7:0]       cnt_wr_data,
    input  logic             cmp_wr_en,
    input  logic [7:0]       cmp_wr_data,
    input  logic             flag_clr,
    output logic [7:0]       cnt_value,
    output logic [7:0]       cmp_value,
    output logic             cmp_flag,
    output logic             cpu_tick
);
    logic cnt_tick;
    logic match;

    ptmr_prescaler u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (clk_sel),
        .cnt_tick_o (cnt_tick),
        .cpu_tick_o (cpu_tick)
    );

    ptmr_count_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_tick_i (cpu_tick),
        .cnt_tick_i (cnt_tick),
        .stopped_i  (clk_sel == '0),
        .cnt_we_i   (cnt_wr_en),
        .cnt_wd_i   (cnt_wr_data),
        .cmp_we_i   (cmp_wr_en),
        .cmp_wd_i   (cmp_wr_data),
        .cnt_o      (cnt_value),
        .cmp_o      (cmp_value),
        .match_o    (match)
    );

    ptmr_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_tick_i (cpu_tick),
        .match_i    (match),
        .clr_i      (flag_clr),
        .flag_o     (cmp_flag)
    );
endmodule

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] clk_sel = '0;
    logic       cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = '0;
    logic       cmp_wr_en = 1'b0;
    logic [7:0] cmp_wr_data = '0;
    logic       flag_clr = 1'b0;
    logic [7:0] cnt_value, cmp_value;
    logic       cmp_flag, cpu_tick;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    typedef struct {
        string tag;
        int    which;   // 0 cnt, 1 cmp, 2 flag, 3 bench measurement
        int    exp;
        int    meas;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    ptmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .flag_clr(flag_clr), .cnt_value(cnt_value), .cmp_value(cmp_value),
        .cmp_flag(cmp_flag), .cpu_tick(cpu_tick)
    );

    task automatic push(string tag, int which, int exp, int meas = 0);
        item_t it;
        it.tag = tag; it.which = which; it.exp = exp; it.meas = meas;
        sb_q.push_back(it);
    endtask

    // monitor: pops expectations and compares with what the design shows now
    initial begin
        forever begin
            item_t it;
            int    got;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            case (it.which)
                0: got = int'(cnt_value);
                1: got = int'(cmp_value);
                2: got = int'(cmp_flag);
                default: got = it.meas;
            endcase
            n_cmp++;
            if (got != it.exp) begin
                n_bad++;
                $display("FAIL %s: got %0d expected %0d", it.tag, got, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_bad++;
            $display("FAIL watchdog R1-R12: got %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_cpu();
        do @(negedge clk); while (!cpu_tick);
    endtask

    task automatic wr_cnt(logic [7:0] v);
        wait_cpu();
        cnt_wr_en = 1'b1; cnt_wr_data = v;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic wr_cmp(logic [7:0] v);
        wait_cpu();
        cmp_wr_en = 1'b1; cmp_wr_data = v;
        @(negedge clk);
        cmp_wr_en = 1'b0;
    endtask

    task automatic clear_on_cpu_edge();
        wait_cpu();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic run_until(logic [7:0] v);
        do begin wait_cpu(); @(negedge clk); end while (cnt_value != v);
    endtask

    task automatic measure(int s, string tag);
        logic [7:0] v;
        int n;
        clk_sel = 4'd0;
        wr_cnt(8'd0);
        wait_cpu();
        @(negedge clk);
        clk_sel = 4'(s);
        v = cnt_value;
        while (cnt_value == v) @(negedge clk);
        v = cnt_value;
        n = 0;
        while (cnt_value == v) begin @(negedge clk); n++; end
        push(tag, 3, 1 << (s - 1), n);
        push({tag, " step"}, 0, int'(v) + 1);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 cnt reset", 0, 0);
        push("R1 cmp reset", 1, 0);
        push("R1 flag reset", 2, 0);
        #1;

        // R4: cpu_tick spacing
        begin
            int n;
            wait_cpu();
            n = 0;
            do begin @(negedge clk); n++; end while (!cpu_tick);
            push("R4 cpu_tick spacing", 3, 16, n);
        end

        // R6: delayed counter write
        wr_cnt(8'h40);
        push("R6 old value after write edge", 0, 0);
        wait_cpu(); @(negedge clk);
        push("R6 value after next cpu edge", 0, 8'h40);

        // R7 + R8: writes making registers equal give no match
        wr_cmp(8'h40);
        push("R7 cmp readback", 1, 8'h40);
        repeat (3) wait_cpu();
        @(negedge clk);
        push("R8 no match from cmp write", 2, 0);
        wr_cmp(8'h55);
        wr_cnt(8'h55);
        repeat (3) wait_cpu();
        @(negedge clk);
        push("R8 no match from cnt write", 2, 0);
        push("R2 held while stopped", 0, 8'h55);

        // R2: long stop
        repeat (200) @(negedge clk);
        push("R2 still held", 0, 8'h55);

        // R9: match timing at CPU rate
        wr_cnt(8'h10);
        wr_cmp(8'h13);
        clk_sel = 4'd5;
        run_until(8'h13);
        push("R9 flag low on match edge", 2, 0);
        wait_cpu(); @(negedge clk);
        push("R9 flag high one cpu cycle later", 2, 1);
        push("R4 count one per cpu cycle", 0, 8'h14);
        #1;

        // R10: stays set, off-edge clear ignored
        repeat (4) wait_cpu();
        @(negedge clk);
        push("R10 flag sticky", 2, 1);
        #1;
        @(negedge clk);
        if (cpu_tick) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        push("R10 off-edge clear ignored", 2, 1);
        #1;

        // R11: clear and set on the same CPU edge
        clk_sel = 4'd0;
        wr_cnt(8'h20);
        wr_cmp(8'h22);
        clk_sel = 4'd5;
        run_until(8'h22);
        clear_on_cpu_edge();
        push("R11 set wins over clear", 2, 1);
        #1;
        clear_on_cpu_edge();
        push("R10 clear on cpu edge", 2, 0);
        #1;

        // R12: wrap and compare 0
        clk_sel = 4'd0;
        wr_cnt(8'hFE);
        wr_cmp(8'h00);
        clk_sel = 4'd5;
        run_until(8'hFF);
        wait_cpu(); @(negedge clk);
        push("R12 wrap to zero", 0, 0);
        push("R12 flag low on wrap edge", 2, 0);
        wait_cpu(); @(negedge clk);
        push("R12 flag after wrap match", 2, 1);
        #1;
        clear_on_cpu_edge();

        // R6: load overrides increment at full rate
        clk_sel = 4'd1;
        wr_cnt(8'h80);
        wait_cpu(); @(negedge clk);
        push("R6 load wins over tick", 0, 8'h80);
        #1;
        @(negedge clk);
        push("R6 counting resumes", 0, 8'h81);
        #1;

        // R3 / R4 / R5: tick periods
        for (int s = 1; s < 16; s++) begin
            string t;
            if (s < 5)       t = $sformatf("R3 period sel %0d", s);
            else if (s == 5) t = "R4 period sel 5";
            else             t = $sformatf("R5 period sel %0d", s);
            measure(s, t);
        end

        wait (sb_q.size() == 0);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule